// File: doc/BRIEF.md
# SMM Cache Coherency Sequencer

This block drives the processor's cache-control inputs around entry to and exit from system-management mode. The aim is that cached lines from normal memory and from the management RAM never mix. It watches the active-low management interrupt request and the active-low "in management mode" acknowledge from the processor. Both signals are resynchronised into the local clock. From them it produces three things: a one-clock active-low cache flush pulse with a matching second-level flush strobe, the active-low cache-enable, and the write-policy select (1 = write-back, 0 = write-through).

Three static straps choose the recipe:

- **`cfg_overlaid`**: whether the management RAM overlays normal memory.
- **`cfg_writeback`**: whether the cache runs write-back or write-through.
- **`cfg_cache_in_smm`**: whether caching stays on during management mode.

When the RAM is overlaid, the cache must be flushed. In write-back mode the flush goes out with the request. In write-through mode it goes out on the falling acknowledge, and again on the rising acknowledge when caching was live. When the RAM is not overlaid, no flush is needed. The block either forces write-through or withholds the cache-enable for the duration of management mode.

The management window opens on a synchronised falling edge of either the request or the acknowledge. It closes on a synchronised rising edge of the acknowledge. Outside the window, the cache-enable and write-policy outputs equal the system's normal values in the same cycle.

Top module: `smm_cache_seq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `flush_n` is 1 and `l2_flush` is 0. The management window is closed, so `ken_n` equals `ken_sys_n` and `wbwt` equals `wbwt_sys`.
- R2: Overlaid, write-through (`cfg_overlaid`=1, `cfg_writeback`=0): `smiact_n` is first sampled low at edge k. Then `flush_n` is 0 and `l2_flush` is 1 after edge k+SYNC_STAGES.
- R3: Overlaid, write-through, `cfg_cache_in_smm`=1, and `ken_sys_n`=0 when the entry flush is generated: a second flush pulse follows the rising edge of `smiact_n`, with the same latency as in R2.
- R4: Overlaid, write-through: if KEN is high at entry, no exit flush is produced. KEN high at entry means `cfg_cache_in_smm`=0, or `ken_sys_n`=1 at the entry detection.
- R5: Overlaid, write-through, `cfg_cache_in_smm`=0: `ken_n` is 1 while the window is open.
- R6: Overlaid, write-back (`cfg_overlaid`=1, `cfg_writeback`=1): one flush pulse follows the synchronised falling edge of `smi_req_n`, and none follows edges of `smiact_n`. `ken_n` is 1 while the window is open.
- R7: Non-overlaid (`cfg_overlaid`=0): `flush_n` stays 1 and `l2_flush` stays 0.
- R8: Non-overlaid, write-back, `cfg_cache_in_smm`=1: `wbwt` is 0 while the window is open.
- R9: Non-overlaid, `cfg_cache_in_smm`=0: `ken_n` is 1 while the window is open.
- R10: The window opens after a synchronised falling edge of `smi_req_n` or `smiact_n`, and closes after a synchronised rising edge of `smiact_n`. While it is closed, `ken_n` and `wbwt` follow `ken_sys_n` and `wbwt_sys` combinationally.
- R11: Each flush is exactly one clock of `flush_n`=0, however long the request or acknowledge is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smi_req_n | input | 1 | Management interrupt request, active low, asynchronous |
| smiact_n | input | 1 | Management mode acknowledge, active low, asynchronous |
| cfg_overlaid | input | 1 | 1 = management RAM overlays normal memory |
| cfg_writeback | input | 1 | 1 = cache configured write-back |
| cfg_cache_in_smm | input | 1 | 1 = caching allowed during management mode |
| ken_sys_n | input | 1 | Normal-mode cache enable, active low |
| wbwt_sys | input | 1 | Normal-mode write policy, 1 = write-back |
| flush_n | output | 1 | Processor cache flush, one-clock active-low pulse |
| l2_flush | output | 1 | Second-level cache flush strobe, active high |
| ken_n | output | 1 | Cache enable to processor, active low |
| wbwt | output | 1 | Write policy to processor, 1 = write-back |

## Verification
The bench runs each strap combination through a full request, acknowledge and release sequence, and counts flush cycles against the count the recipe calls for.

- **Exit flush:** a design that ignores the KEN level at entry would flush twice when caching was off.
- **Pulse width:** one that treats levels as edges would stretch the pulse over the whole hold time.
- **Pulse latency:** the latency of the entry pulse is pinned to the synchroniser depth, so an extra or missing register stage shows up as a one-cycle shift.
- **Reset and passthrough:** forcing of the cache-enable and write policy is checked inside the window, and passthrough is checked after it. A reset in the middle of management mode must drop the forcing at once.

// File: rtl/smm_seq_pkg.sv
// Package: recipe encoding shared by the sequencer blocks.
// Assumes the three straps are static while the processor is in management mode.
package smm_seq_pkg;

    typedef enum logic [2:0] {
        RCP_OVL_WT_CACHE = 3'd0,  // overlaid, write-through, caching on
        RCP_OVL_WT_NC    = 3'd1,  // overlaid, write-through, caching off
        RCP_OVL_WB       = 3'd2,  // overlaid, write-back
        RCP_NOV_WB_CACHE = 3'd3,  // separate RAM, write-back, caching on
        RCP_NOV_NC       = 3'd4,  // separate RAM, caching off
        RCP_NOV_PASS     = 3'd5   // separate RAM, write-through, caching on
    } recipe_t;

    // Map the straps to one timing recipe.
    function automatic recipe_t pick_recipe(input logic ovl, input logic wb,
                                            input logic cache_on);
        recipe_t r;
        if (ovl) begin
            if (wb)            r = RCP_OVL_WB;
            else if (cache_on) r = RCP_OVL_WT_CACHE;
            else               r = RCP_OVL_WT_NC;
        end else begin
            if (!cache_on)     r = RCP_NOV_NC;
            else if (wb)       r = RCP_NOV_WB_CACHE;
            else               r = RCP_NOV_PASS;
        end
        return r;
    endfunction

endpackage

// File: rtl/smm_sync.sv
// Module: multi-stage synchroniser for a vector of independent active-low levels.
// Assumes each bit is a slow level; resets every stage to 1 (inactive).
module smm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift each input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/smm_edge_det.sv
// Module: rise/fall detection on synchronised levels, one flop of history per bit.
// Assumes inputs are already in the clock domain; history resets to 1.
module smm_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] fall,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            // Compare current and previous level per bit.
            assign fall[g] = prev_q[g] & ~lvl[g];
            assign rise[g] = ~prev_q[g] & lvl[g];
        end
    endgenerate

endmodule

// File: rtl/smm_flush_ctl.sv
// Module: management window tracking, exit-flush arming and flush pulse generation.
// Assumes one-cycle edge strobes; flush outputs are registered single-cycle pulses.
module smm_flush_ctl
    import smm_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  recipe_t recipe,
    input  logic    smi_fall,
    input  logic    act_fall,
    input  logic    act_rise,
    input  logic    ken_sys_n,
    output logic    win,
    output logic    flush_n,
    output logic    l2_flush
);
    logic win_q;
    logic arm_q;
    logic wt_rcp;
    logic entry_hit;
    logic exit_hit;
    logic fire;

    // Classify which edges call for a flush under the current recipe.
    always_comb begin
        wt_rcp    = (recipe == RCP_OVL_WT_CACHE) || (recipe == RCP_OVL_WT_NC);
        entry_hit = (wt_rcp && act_fall) || ((recipe == RCP_OVL_WB) && smi_fall);
        exit_hit  = wt_rcp && act_rise && arm_q;
        fire      = entry_hit || exit_hit;
    end

    // Open the window on request or acknowledge fall, close on acknowledge rise.
    always_ff @(posedge clk) begin
        if (!rst_n)                    win_q <= 1'b0;
        else if (act_rise)             win_q <= 1'b0;
        else if (smi_fall || act_fall) win_q <= 1'b1;
    end

    // Arm the exit flush only when the cache was live at the entry flush.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (act_rise)
            arm_q <= 1'b0;
        else if (wt_rcp && act_fall)
            arm_q <= (recipe == RCP_OVL_WT_CACHE) && !ken_sys_n;
    end

    // Register the flush pulse for both cache levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_n  <= 1'b1;
            l2_flush <= 1'b0;
        end else begin
            flush_n  <= ~fire;
            l2_flush <= fire;
        end
    end

    assign win = win_q;

endmodule

// File: rtl/smm_policy_mux.sv
// Module: selects forced or pass-through cache enable and write policy.
// Assumes win is registered; the outputs are combinational from it and the system values.
module smm_policy_mux
    import smm_seq_pkg::*;
(
    input  recipe_t recipe,
    input  logic    win,
    input  logic    ken_sys_n,
    input  logic    wbwt_sys,
    output logic    ken_n,
    output logic    wbwt
);
    logic kill_cache;
    logic force_wt;

    // Decide which override applies inside the window.
    always_comb begin
        kill_cache = (recipe == RCP_OVL_WB) || (recipe == RCP_OVL_WT_NC) ||
                     (recipe == RCP_NOV_NC);
        force_wt   = (recipe == RCP_NOV_WB_CACHE);
        ken_n      = (win && kill_cache) ? 1'b1 : ken_sys_n;
        wbwt       = (win && force_wt)   ? 1'b0 : wbwt_sys;
    end

endmodule

// File: rtl/smm_cache_seq.sv
// Module: top of the management-mode cache coherency sequencer.
// Assumes asynchronous request/acknowledge inputs and static straps; reset is synchronous.
module smm_cache_seq
    import smm_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smi_req_n,
    input  logic smiact_n,
    input  logic cfg_overlaid,
    input  logic cfg_writeback,
    input  logic cfg_cache_in_smm,
    input  logic ken_sys_n,
    input  logic wbwt_sys,
    output logic flush_n,
    output logic l2_flush,
    output logic ken_n,
    output logic wbwt
);
    localparam int NSIG    = 2;
    localparam int IDX_SMI = 0;
    localparam int IDX_ACT = 1;

    logic [NSIG-1:0] raw_lvl;
    logic [NSIG-1:0] sync_lvl;
    logic [NSIG-1:0] fall_v;
    logic [NSIG-1:0] rise_v;
    recipe_t         recipe;
    logic            win;

    assign raw_lvl[IDX_SMI] = smi_req_n;
    assign raw_lvl[IDX_ACT] = smiact_n;

    // Decode straps to the active recipe.
    always_comb recipe = pick_recipe(cfg_overlaid, cfg_writeback, cfg_cache_in_smm);

    smm_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lvl),
        .dout (sync_lvl)
    );

    smm_edge_det #(.WIDTH(NSIG)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sync_lvl),
        .fall (fall_v),
        .rise (rise_v)
    );

    smm_flush_ctl u_flush (
        .clk      (clk),
        .rst_n    (rst_n),
        .recipe   (recipe),
        .smi_fall (fall_v[IDX_SMI]),
        .act_fall (fall_v[IDX_ACT]),
        .act_rise (rise_v[IDX_ACT]),
        .ken_sys_n(ken_sys_n),
        .win      (win),
        .flush_n  (flush_n),
        .l2_flush (l2_flush)
    );

    smm_policy_mux u_mux (
        .recipe   (recipe),
        .win      (win),
        .ken_sys_n(ken_sys_n),
        .wbwt_sys (wbwt_sys),
        .ken_n    (ken_n),
        .wbwt     (wbwt)
    );

endmodule

// File: rtl/smm_cache_seq_chk.sv
// Module: assertion checker bound into the sequencer top.
// Assumes straps change only while no flush is pending.
module smm_cache_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_overlaid,
    input logic cfg_writeback,
    input logic cfg_cache_in_smm,
    input logic ken_sys_n,
    input logic wbwt_sys,
    input logic flush_n,
    input logic l2_flush,
    input logic ken_n,
    input logic wbwt,
    input logic win,
    input logic act_rise
);
    AST_L2_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        l2_flush |-> !flush_n); // R2

    AST_NOV_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_overlaid && $stable(cfg_overlaid)) |-> flush_n); // R7

    AST_OVL_WB_KEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_overlaid && cfg_writeback && win) |-> ken_n); // R6

    AST_NOV_FORCE_WT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_overlaid && cfg_writeback && cfg_cache_in_smm && win) |-> !wbwt); // R8

    AST_WIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        act_rise |=> !win); // R10

    AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !win |-> (ken_n == ken_sys_n && wbwt == wbwt_sys)); // R10

endmodule

bind smm_cache_seq smm_cache_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_overlaid    (cfg_overlaid),
    .cfg_writeback   (cfg_writeback),
    .cfg_cache_in_smm(cfg_cache_in_smm),
    .ken_sys_n       (ken_sys_n),
    .wbwt_sys        (wbwt_sys),
    .flush_n         (flush_n),
    .l2_flush        (l2_flush),
    .ken_n           (ken_n),
    .wbwt            (wbwt),
    .win             (win),
    .act_rise        (rise_v[1])
);

// File: tb/smm_cache_seq_bench.sv
// Bench: behavioural reference model compared every clock, plus directed scenario checks.
module smm_cache_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int WDOG_MAX   = 20000;

    logic clk = 1'b0;
    logic rst_n, smi_req_n, smiact_n, cfg_overlaid, cfg_writeback, cfg_cache_in_smm;
    logic ken_sys_n, wbwt_sys;
    logic flush_n, l2_flush, ken_n, wbwt;

    int errors = 0;
    int checks = 0;
    int fcount = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    int  q_smi[$];
    int  q_act[$];
    bit  m_win, m_arm, m_flush;

    smm_cache_seq #(.SYNC_STAGES(SYNC)) u_smm_cache_seq (
        .clk(clk), .rst_n(rst_n), .smi_req_n(smi_req_n), .smiact_n(smiact_n),
        .cfg_overlaid(cfg_overlaid), .cfg_writeback(cfg_writeback),
        .cfg_cache_in_smm(cfg_cache_in_smm), .ken_sys_n(ken_sys_n), .wbwt_sys(wbwt_sys),
        .flush_n(flush_n), .l2_flush(l2_flush), .ken_n(ken_n), .wbwt(wbwt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string flush_tag();
        if (!cfg_overlaid) return "R7";
        if (cfg_writeback) return "R6";
        return "R2";
    endfunction

    function automatic string ken_tag();
        if (!m_win)        return "R10";
        if (!cfg_overlaid) return "R9";
        if (cfg_writeback) return "R6";
        return "R5";
    endfunction

    // Reference model: advance on each edge, compare a quarter period later.
    always @(posedge clk) begin
        bit sf, af, ar, exp_ken, exp_wbwt, kill, fire;
        cycles++;
        if (!rst_n) begin
            q_smi = {};
            q_act = {};
            for (int i = 0; i < SYNC + 2; i++) begin
                q_smi.push_front(1);
                q_act.push_front(1);
            end
            m_win = 0; m_arm = 0; m_flush = 1;
        end else begin
            q_smi.push_front(int'(smi_req_n));
            q_act.push_front(int'(smiact_n));
            while (q_smi.size() > SYNC + 2) begin
                void'(q_smi.pop_back());
                void'(q_act.pop_back());
            end
            sf = (q_smi[SYNC+1] == 1) && (q_smi[SYNC] == 0);
            af = (q_act[SYNC+1] == 1) && (q_act[SYNC] == 0);
            ar = (q_act[SYNC+1] == 0) && (q_act[SYNC] == 1);
            fire = 0;
            if (cfg_overlaid && cfg_writeback && sf) fire = 1;
            if (cfg_overlaid && !cfg_writeback && af) fire = 1;
            if (cfg_overlaid && !cfg_writeback && ar && m_arm) fire = 1;
            if (ar) m_arm = 0;
            else if (cfg_overlaid && !cfg_writeback && af)
                m_arm = cfg_cache_in_smm && !ken_sys_n;
            if (ar) m_win = 0;
            else if (sf || af) m_win = 1;
            m_flush = !fire;
        end
        started = 1;
        #(CLK_PERIOD/4);
        if (!done) begin
            kill = m_win && ((cfg_overlaid && cfg_writeback) ||
                             (cfg_overlaid && !cfg_cache_in_smm) ||
                             (!cfg_overlaid && !cfg_cache_in_smm));
            exp_ken  = kill ? 1'b1 : ken_sys_n;
            exp_wbwt = (m_win && !cfg_overlaid && cfg_writeback && cfg_cache_in_smm) ? 1'b0 : wbwt_sys;
            check(flush_tag(), flush_n, m_flush, "flush_n per cycle");
            check(flush_tag(), l2_flush, !m_flush, "l2_flush per cycle");
            check(ken_tag(), ken_n, exp_ken, "ken_n per cycle");
            check(m_win ? "R8" : "R10", wbwt, exp_wbwt, "wbwt per cycle");
            if (!flush_n) fcount++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > WDOG_MAX && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired: actual=%0d expected<%0d", cycles, WDOG_MAX);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One full SMM entry/exit under a given strap set.
    task automatic scen(input bit ovl, input bit wb, input bit cache, input bit ksys,
                        input int exp_flush, input string tag);
        @(negedge clk);
        cfg_overlaid = ovl; cfg_writeback = wb; cfg_cache_in_smm = cache;
        ken_sys_n = ksys; wbwt_sys = 1'b1;
        repeat (6) @(negedge clk);
        fcount = 0;
        smi_req_n = 1'b0;
        repeat (3) @(negedge clk);
        smiact_n = 1'b0;
        repeat (SYNC + 1) @(posedge clk);
        #(CLK_PERIOD/4);
        if (ovl && !wb) begin
            check("R2", flush_n, 0, "entry flush latency");
            check("R2", l2_flush, 1, "entry l2 flush");
            @(posedge clk); #(CLK_PERIOD/4);
            check("R11", flush_n, 1, "flush width one cycle");
        end
        @(negedge clk);
        repeat (5) @(negedge clk);
        ken_sys_n = 1'b0;
        @(posedge clk); #(CLK_PERIOD/4);
        if (ovl && !wb && !cache) check("R5", ken_n, 1, "ken forced off in window");
        if (ovl && wb)            check("R6", ken_n, 1, "ken forced off in window");
        if (!ovl && !cache)       check("R9", ken_n, 1, "ken forced off in window");
        if (!ovl && wb && cache)  check("R8", wbwt, 0, "write-through forced");
        @(negedge clk);
        smi_req_n = 1'b1;
        repeat (3) @(negedge clk);
        smiact_n = 1'b1;
        repeat (8) @(negedge clk);
        #1;
        check("R10", ken_n, ken_sys_n, "ken passthrough after exit");
        check("R10", wbwt, wbwt_sys, "wbwt passthrough after exit");
        check(tag, fcount, exp_flush, "flush cycle count");
    endtask

    initial begin
        rst_n = 1'b0; smi_req_n = 1'b1; smiact_n = 1'b1;
        cfg_overlaid = 1'b1; cfg_writeback = 1'b0; cfg_cache_in_smm = 1'b1;
        ken_sys_n = 1'b0; wbwt_sys = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", flush_n, 1, "reset flush_n");
        check("R1", l2_flush, 0, "reset l2_flush");
        check("R1", ken_n, 0, "reset ken passthrough");
        rst_n = 1'b1;
        scen(1, 0, 1, 0, 2, "R3");
        scen(1, 0, 0, 0, 1, "R4");
        scen(1, 0, 1, 1, 1, "R4");
        scen(1, 1, 1, 0, 1, "R11");
        scen(1, 1, 0, 0, 1, "R6");
        scen(0, 1, 1, 0, 0, "R7");
        scen(0, 0, 0, 0, 0, "R7");
        scen(0, 0, 1, 0, 0, "R7");
        // reset during management mode drops forcing at once
        @(negedge clk);
        cfg_overlaid = 1; cfg_writeback = 1; ken_sys_n = 0;
        smi_req_n = 0;
        repeat (6) @(negedge clk);
        check("R6", ken_n, 1, "ken off before reset");
        rst_n = 0; smi_req_n = 1;
        @(negedge clk);
        check("R1", ken_n, 0, "ken passthrough after mid-SMM reset");
        check("R1", flush_n, 1, "flush idle after mid-SMM reset");
        rst_n = 1;
        repeat (6) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule